// File: doc/BRIEF.md
# Lock-Gated Serial Audio Clock Generator

This block turns a fast master clock into the clocks a serial audio link needs: a master clock output, a bit clock and a frame (left/right) clock. Whether each one runs depends on two power-enable bits, a PLL lock flag, a master/slave select and a master-clock-output enable. All control inputs are asynchronous. A synchronizer brings them into the master clock domain before any logic uses them.

In master mode the block drives the bit and frame clocks. They start only after power-up and lock, always at a frame boundary, and they stop only once the current frame has finished. The number of bit clocks in a frame is selectable. In slave mode the bit and frame pins are inputs, so the block only gates the master clock output. That output may carry the not-yet-settled PLL clock while unlocked, provided its enable is set.

A separate combinational decoder checks the 4-bit sampling-range code. It turns a valid code into a range index and flags any unsupported code.

Top module: `aclk_gate_top`

## Requirements
- R1: When either power bit is 0, `mclk_o`, `bclk_o` and `lrclk_o` are all low from the third rising clock edge after the input change, and they stay low until both power bits are 1 again. The serial generator returns to its idle state without finishing the frame.
- R2: In master mode, powered up but with `lock_i` low, the serial generator stays idle and `bclk_o` and `lrclk_o` stay low.
- R3: While running, `bclk_o` has a period of 2·`BCLK_HALF_DIV` master clocks. One `lrclk_o` period holds 64 bit-clock periods when the latched rate is 1, or 32 when it is 0. `lrclk_o` is low for the first half of the frame and high for the second half, and it changes only on a falling edge of `bclk_o`.
- R4: When `mclk_en_i` is 0, `mclk_o` is low.
- R5: When powered and enabled, `mclk_o` runs at half the master clock whatever the state of `lock_i`. Each high phase lasts exactly one master clock.
- R6: `clk_oe_o` follows the synchronized master select, with the same latency as R1. In slave mode (`master_i` = 0) `clk_oe_o` is 0 and an idle generator never starts.
- R7: The generator starts only from a frame boundary. In the first cycle after the start, `bclk_o` and `lrclk_o` are both low.
- R8: When lock or master mode is lost while running, the current frame completes in full and the outputs stop low at the frame boundary.
- R9: A change to `rate64_i` while running takes effect only at the next frame boundary.
- R10: The range decoder maps codes 4'b1000 to 4'b1100 onto `fs_idx_o` 0 to 4 with `fs_bad_o` = 0. Code 4'b1000 is the widest range, 32 to 48 kHz, and 4'b1100 is the narrowest, 8 to 12 kHz. Every other code gives `fs_bad_o` = 1 and `fs_idx_o` = 0.
- R11: Every control input passes through a two-flop synchronizer. A change present before rising edge k affects the outputs registered at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast master clock from the PLL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_pwr_i | input | 1 | PLL power enable |
| dac_pwr_i | input | 1 | Converter power enable |
| lock_i | input | 1 | PLL lock flag, asynchronous |
| master_i | input | 1 | 1 = master mode (drive bit/frame clocks), 0 = slave |
| mclk_en_i | input | 1 | Master clock output enable |
| rate64_i | input | 1 | 1 = 64 bit clocks per frame, 0 = 32 |
| fs_code_i | input | 4 | Sampling-range code |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| clk_oe_o | output | 1 | Drive enable for the bit and frame clock pins |
| fs_idx_o | output | 3 | Decoded range index, 0 = widest |
| fs_bad_o | output | 1 | Unsupported range code |

## Verification
The timing properties assume that each control input holds its level for at least one master clock, so the synchronizer delay is exactly three edges from input to checked output. They also assume the checker is bound with the default two synchronizer stages. The stimulus changes inputs only on falling edges, holds every level for many cycles, and drops lock or power at arbitrary points within a frame, so the stop paths are exercised with the counters mid-frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   localparam logic [3:0] FS_CODE_FIRST = 4'b1000;
   localparam int unsigned FS_CODE_COUNT = 5;

   typedef logic [2:0] fs_idx_t;

   typedef enum logic {
      GEN_IDLE = 1'b0,
      GEN_RUN  = 1'b1
   } gen_state_e;

   function automatic logic fs_code_ok(input logic [3:0] code);
      return (int'(code) >= int'(FS_CODE_FIRST)) &&
             (int'(code) <  int'(FS_CODE_FIRST) + int'(FS_CODE_COUNT));
   endfunction

endpackage

// File: rtl/aclk_sync.sv
module aclk_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aclk_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("aclk_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/aclk_mclk_gate.sv
module aclk_mclk_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_i,
   input  logic en_i,
   output logic mclk_o
);

   logic mclk_q;

   // A high phase always completes: a stop request only suppresses the next rise.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mclk_q <= 1'b0;
      else if (!pwr_i)  mclk_q <= 1'b0;
      else              mclk_q <= ~mclk_q & en_i;
   end

   assign mclk_o = mclk_q;

endmodule

// File: rtl/aclk_serial_gen.sv
module aclk_serial_gen #(
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned BITS_WIDE   = 64,
   parameter int unsigned BITS_NARROW = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_i,
   input  logic go_i,
   input  logic wide_i,
   output logic bclk_o,
   output logic lrclk_o
);
   import aclk_pkg::*;

   localparam int unsigned HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int unsigned BW = $clog2(BITS_WIDE);
   localparam logic [BW-1:0] LAST_WIDE   = BW'(BITS_WIDE - 1);
   localparam logic [BW-1:0] LAST_NARROW = BW'(BITS_NARROW - 1);
   localparam logic [BW-1:0] MID_WIDE    = BW'(BITS_WIDE / 2 - 1);
   localparam logic [BW-1:0] MID_NARROW  = BW'(BITS_NARROW / 2 - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("aclk_serial_gen: HALF_DIV must be at least 1");
   end
   if (BITS_NARROW < 2 || BITS_NARROW >= BITS_WIDE ||
       (BITS_WIDE & (BITS_WIDE - 1)) != 0 ||
       (BITS_NARROW & (BITS_NARROW - 1)) != 0) begin : g_bad_bits
      $error("aclk_serial_gen: frame lengths must be powers of two, narrow < wide");
   end

   gen_state_e    state_q;
   logic [BW-1:0] bit_q;
   logic          wide_q;
   logic          bclk_q;
   logic          lr_q;
   logic          half_end;

   if (HALF_DIV == 1) begin : g_no_presc
      assign half_end = 1'b1;
   end else begin : g_presc
      logic [HW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          cnt_q <= '0;
         else if (!pwr_i || state_q != GEN_RUN) cnt_q <= '0;
         else if (half_end)                     cnt_q <= '0;
         else                                   cnt_q <= cnt_q + 1'b1;
      end
      assign half_end = (cnt_q == HW'(HALF_DIV - 1));
   end

   logic last_bit;
   logic mid_bit;
   assign last_bit = (bit_q == (wide_q ? LAST_WIDE : LAST_NARROW));
   assign mid_bit  = (bit_q == (wide_q ? MID_WIDE : MID_NARROW));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= GEN_IDLE;
         bit_q   <= '0;
         wide_q  <= 1'b1;
         bclk_q  <= 1'b0;
         lr_q    <= 1'b0;
      end else if (!pwr_i) begin
         state_q <= GEN_IDLE;
         bit_q   <= '0;
         bclk_q  <= 1'b0;
         lr_q    <= 1'b0;
      end else begin
         unique case (state_q)
            GEN_IDLE: begin
               if (go_i) begin
                  state_q <= GEN_RUN;
                  wide_q  <= wide_i;
               end
            end
            GEN_RUN: begin
               if (half_end) begin
                  bclk_q <= ~bclk_q;
                  if (bclk_q) begin
                     if (last_bit) begin
                        bit_q  <= '0;
                        lr_q   <= 1'b0;
                        wide_q <= wide_i;
                        if (!go_i) state_q <= GEN_IDLE;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                        if (mid_bit) lr_q <= 1'b1;
                     end
                  end
               end
            end
            default: state_q <= GEN_IDLE;
         endcase
      end
   end

   assign bclk_o  = bclk_q;
   assign lrclk_o = lr_q;

endmodule

// File: rtl/aclk_gate_top.sv
module aclk_gate_top #(
   parameter int unsigned BCLK_HALF_DIV     = 2,
   parameter int unsigned FRAME_BITS_WIDE   = 64,
   parameter int unsigned FRAME_BITS_NARROW = 32,
   parameter int unsigned SYNC_STAGES       = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       pll_pwr_i,
   input  logic       dac_pwr_i,
   input  logic       lock_i,
   input  logic       master_i,
   input  logic       mclk_en_i,
   input  logic       rate64_i,
   input  logic [3:0] fs_code_i,
   output logic       mclk_o,
   output logic       bclk_o,
   output logic       lrclk_o,
   output logic       clk_oe_o,
   output logic [2:0] fs_idx_o,
   output logic       fs_bad_o
);
   import aclk_pkg::*;

   localparam int unsigned NCTRL = 6;

   logic [NCTRL-1:0] ctrl_raw;
   logic [NCTRL-1:0] ctrl_s;
   logic             pll_s, dac_s, lock_s, master_s, en_s, rate_s;
   logic             pwr_s;
   logic             oe_q;

   assign ctrl_raw = {pll_pwr_i, dac_pwr_i, lock_i, master_i, mclk_en_i, rate64_i};

   aclk_sync #(.WIDTH(NCTRL), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ctrl_raw),
      .q_o    (ctrl_s)
   );

   assign {pll_s, dac_s, lock_s, master_s, en_s, rate_s} = ctrl_s;
   assign pwr_s = pll_s & dac_s;

   aclk_mclk_gate u_mclk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pwr_i  (pwr_s),
      .en_i   (en_s),
      .mclk_o (mclk_o)
   );

   aclk_serial_gen #(
      .HALF_DIV    (BCLK_HALF_DIV),
      .BITS_WIDE   (FRAME_BITS_WIDE),
      .BITS_NARROW (FRAME_BITS_NARROW)
   ) u_gen (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pwr_i   (pwr_s),
      .go_i    (lock_s & master_s),
      .wide_i  (rate_s),
      .bclk_o  (bclk_o),
      .lrclk_o (lrclk_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) oe_q <= 1'b0;
      else         oe_q <= master_s;
   end
   assign clk_oe_o = oe_q;

   assign fs_bad_o = ~fs_code_ok(fs_code_i);
   assign fs_idx_o = fs_code_ok(fs_code_i) ? fs_idx_t'(fs_code_i - FS_CODE_FIRST) : '0;

endmodule

// File: rtl/aclk_gate_chk.sv
module aclk_gate_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic pll_pwr_i,
   input logic dac_pwr_i,
   input logic master_i,
   input logic mclk_en_i,
   input logic mclk_o,
   input logic bclk_o,
   input logic lrclk_o,
   input logic clk_oe_o
);

   // R1
   pwr_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(pll_pwr_i && dac_pwr_i, 3) |-> (!mclk_o && !bclk_o && !lrclk_o));

   // R4
   mclk_disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(mclk_en_i, 3) |-> !mclk_o);

   // R5
   mclk_single_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mclk_o |=> !mclk_o);

   // R6
   slave_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(master_i, 3) |-> !clk_oe_o);

   // R3
   frame_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(lrclk_o) && $past(pll_pwr_i && dac_pwr_i, 3)) |-> $fell(bclk_o));

endmodule

bind aclk_gate_top aclk_gate_chk chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .pll_pwr_i (pll_pwr_i),
   .dac_pwr_i (dac_pwr_i),
   .master_i  (master_i),
   .mclk_en_i (mclk_en_i),
   .mclk_o    (mclk_o),
   .bclk_o    (bclk_o),
   .lrclk_o   (lrclk_o),
   .clk_oe_o  (clk_oe_o)
);

// File: tb/aclk_gate_top_tb.sv
`timescale 1ns/1ps
module aclk_gate_top_tb_top;

   localparam int HALF = 2;
   localparam int WIDE = 64;
   localparam int NARROW = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll_pwr = 1'b0, dac_pwr = 1'b0, lock = 1'b0, master = 1'b0;
   logic       mclk_en = 1'b0, rate64 = 1'b1;
   logic [3:0] fs_code = 4'b1000;
   logic       mclk, bclk, lrclk, oe, fs_bad;
   logic [2:0] fs_idx;

   int    n_checks = 0;
   int    n_errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   aclk_gate_top #(
      .BCLK_HALF_DIV(HALF), .FRAME_BITS_WIDE(WIDE), .FRAME_BITS_NARROW(NARROW)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pll_pwr_i(pll_pwr), .dac_pwr_i(dac_pwr),
      .lock_i(lock), .master_i(master), .mclk_en_i(mclk_en), .rate64_i(rate64),
      .fs_code_i(fs_code), .mclk_o(mclk), .bclk_o(bclk), .lrclk_o(lrclk),
      .clk_oe_o(oe), .fs_idx_o(fs_idx), .fs_bad_o(fs_bad)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: inputs delayed two edges, then a frame-time counter.
   int q_pwr[$], q_lock[$], q_ms[$], q_en[$], q_rate[$];
   bit e_mclk = 0, e_oe = 0, e_run = 0;
   int t = 0;
   int bits = WIDE;

   function automatic bit exp_bclk();
      return e_run && (((t / HALF) % 2) == 1);
   endfunction
   function automatic bit exp_lr();
      return e_run && (t >= bits * HALF);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_pwr = {0, 0}; q_lock = {0, 0}; q_ms = {0, 0}; q_en = {0, 0}; q_rate = {0, 0};
         e_mclk = 0; e_oe = 0; e_run = 0; t = 0; bits = WIDE;
      end else begin
         automatic int p = q_pwr.pop_front();
         automatic int lk = q_lock.pop_front();
         automatic int ms = q_ms.pop_front();
         automatic int en = q_en.pop_front();
         automatic int rt = q_rate.pop_front();
         if (p == 0) e_mclk = 0;
         else if (e_mclk) e_mclk = 0;
         else e_mclk = (en != 0);
         e_oe = (ms != 0);
         if (p == 0) begin
            e_run = 0; t = 0;
         end else if (e_run) begin
            t++;
            if (t == bits * 2 * HALF) begin
               t = 0;
               if (lk == 0 || ms == 0) e_run = 0;
               else bits = (rt != 0) ? WIDE : NARROW;
            end
         end else if (lk != 0 && ms != 0) begin
            e_run = 1; t = 0; bits = (rt != 0) ? WIDE : NARROW;
         end
         q_pwr.push_back(int'(pll_pwr && dac_pwr));
         q_lock.push_back(int'(lock));
         q_ms.push_back(int'(master));
         q_en.push_back(int'(mclk_en));
         q_rate.push_back(int'(rate64));
      end
   end

   // Per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "mclk", int'(mclk), int'(e_mclk));
         check(tag, "bclk", int'(bclk), int'(exp_bclk()));
         check(tag, "lrclk", int'(lrclk), int'(exp_lr()));
         check(tag, "clk_oe", int'(oe), int'(e_oe));
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      // Reset state (R1)
      cycles(3);
      check("R1", "reset mclk", int'(mclk), 0);
      check("R1", "reset bclk", int'(bclk), 0);
      check("R1", "reset lrclk", int'(lrclk), 0);
      check("R1", "reset oe", int'(oe), 0);
      rst_n = 1'b1;
      cycles(10);

      // R10: range code decoding
      for (int c = 0; c < 16; c++) begin
         fs_code = 4'(c);
         #1;
         check("R10", "fs_bad", int'(fs_bad), (c >= 8 && c <= 12) ? 0 : 1);
         check("R10", "fs_idx", int'(fs_idx), (c >= 8 && c <= 12) ? c - 8 : 0);
      end
      fs_code = 4'b1000;
      @(negedge clk);

      // R1: only one power bit set
      tag = "R1"; master = 1; mclk_en = 1; pll_pwr = 1;
      cycles(20);
      // R2, R5: powered, unlocked, mclk passes the unsettled clock
      tag = "R2,R5"; dac_pwr = 1;
      cycles(60);
      // R11, R7: lock arrives, start latency and frame-boundary start
      tag = "R11,R7"; lock = 1;
      cycles(12);
      // R3: wide frames
      tag = "R3"; cycles(3 * 2 * HALF * WIDE);
      // R9: rate change mid-frame
      cycles(37);
      tag = "R9"; rate64 = 0;
      cycles(2 * 2 * HALF * WIDE);
      // R8: lock lost mid-frame
      cycles(41);
      tag = "R8"; lock = 0;
      cycles(2 * HALF * WIDE);
      // R4: master clock output disabled
      tag = "R4"; mclk_en = 0;
      cycles(20);
      // R6: slave mode with lock, generator must not start
      tag = "R6"; master = 0; lock = 1; mclk_en = 1;
      cycles(200);
      // R3: master again, narrow frames
      tag = "R3"; master = 1;
      cycles(2 * 2 * HALF * NARROW + 29);
      // R1: power removed mid-frame
      tag = "R1"; dac_pwr = 0;
      cycles(50);
      tag = "R1"; pll_pwr = 0; dac_pwr = 1;
      cycles(20);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule